// File: doc/BRIEF.md
# Eight-Digit Multiplexed Seven-Segment Scanner

This block lights an eight-position common-anode seven-segment display from one 32-bit word that carries eight packed BCD nibbles. Only one position is powered at a time. A slow scan strobe, nominally 1 kHz, steps a position index. The index selects one nibble, powers the matching position and turns the nibble into a segment pattern. At that rate the eye sees all eight positions lit at once.

The word is sampled continuously and has no handshake. Whatever value is present on the clock edge is the value displayed for the current position. A decimal point is lit after positions 6, 4 and 2, which splits a clock-style word into four two-digit fields. Both the segment lines and the position enables are active low. The segment pattern and the position enable come from the same index value and are registered together, so they always change on the same edge.

Top module: `seg_scan_top`

## Requirements
- R1: While `rst` is high at a clock edge, the index returns to 0. On the next edge `seg_n` and `dig_n` are all ones (blank, every position off). The first position shown after reset is position 0.
- R2: A cycle with `scan_tick` high advances the index by one, and the index wraps from 7 to 0. A cycle with `scan_tick` low leaves it unchanged.
- R3: When the index is k, position k shows nibble k of `bcd_word` (bits 4k+3..4k). Only `dig_n[k]` is 0 and the other enables are 1. Position 7 is the leftmost position.
- R4: Segment bits map as follows: bit 7 is a, bits 6..1 are b..g, and bit 0 is the decimal point. All bits are active low. For digits 0 to 9 the lit-segment (active-high) codes are FC, 60, DA, F2, 66, B6, BE, E0, FE and F6 hex, with the point bit clear.
- R5: A nibble value from 10 to 15 blanks that position: every segment line, including the point, is 1.
- R6: For a nibble of 0 to 9, the point (`seg_n[0]`) is 0 on positions 6, 4 and 2, and 1 on all other positions.
- R7: The outputs are registered. They reflect the index and word of the previous cycle, and `seg_n` and `dig_n` change on the same edge. A change of the word with no strobe shows up one cycle later on the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_tick | input | 1 | One-cycle strobe that advances the position |
| bcd_word | input | 32 | Eight packed BCD nibbles; nibble 7 is leftmost |
| seg_n | output | 8 | Segments a..g, point (bit 7..0), active low |
| dig_n | output | 8 | Position enables, one-hot, active low |

## Verification
The assertions take `scan_tick` as an ordinary synchronous level that is valid at every edge. They take `bcd_word` as free to change in any cycle. They also assume reset is held for at least one edge before any check counts. The stimulus drives every input on the falling edge. It pulses the strobe for exactly one cycle and changes the word only between strobes. This means each expected output belongs to a single known index and word value.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int SEG_W    = 8;
  localparam int NIB_W    = 4;
  localparam int SEG_A_B  = 7;
  localparam int SEG_DP_B = 0;
  typedef logic [SEG_W-1:0] seg_pat_t;
endpackage

// File: rtl/scan_index_ctr.sv
module scan_index_ctr #(
  parameter int DIGITS = 8,
  localparam int IDX_W = $clog2(DIGITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DIGITS - 1);

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (step) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/digit_select.sv
module digit_select #(
  parameter int DIGITS = 8,
  parameter int NIB_W  = 4,
  localparam int IDX_W = $clog2(DIGITS),
  localparam int WORD_W = DIGITS * NIB_W
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] word,
  output logic [NIB_W-1:0]  nib,
  output logic [DIGITS-1:0] pos_onehot
);
  logic [NIB_W-1:0] nib_arr [DIGITS];

  for (genvar k = 0; k < DIGITS; k++) begin : g_pos
    assign nib_arr[k]    = word[k*NIB_W +: NIB_W];
    assign pos_onehot[k] = (idx == IDX_W'(k));
  end

  assign nib = nib_arr[idx];
endmodule

// File: rtl/seg_encode.sv
module seg_encode
  import seg_scan_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter logic [DIGITS-1:0] DP_MASK = 8'b0101_0100
) (
  input  logic [NIB_W-1:0]  nib,
  input  logic [DIGITS-1:0] pos_onehot,
  output seg_pat_t          lit
);
  seg_pat_t shape;
  logic     want_dp;

  always_comb begin
    unique case (nib)
      4'd0:    shape = 8'hFC;
      4'd1:    shape = 8'h60;
      4'd2:    shape = 8'hDA;
      4'd3:    shape = 8'hF2;
      4'd4:    shape = 8'h66;
      4'd5:    shape = 8'hB6;
      4'd6:    shape = 8'hBE;
      4'd7:    shape = 8'hE0;
      4'd8:    shape = 8'hFE;
      4'd9:    shape = 8'hF6;
      default: shape = 8'h00;
    endcase
  end

  assign want_dp = |(pos_onehot & DP_MASK) && (nib < 4'd10);

  always_comb begin
    lit = shape;
    lit[SEG_DP_B] = want_dp;
  end
endmodule

// File: rtl/seg_scan_top.sv
module seg_scan_top
  import seg_scan_pkg::*;
#(
  parameter int DIGITS = 8,
  parameter logic [DIGITS-1:0] DP_MASK = 8'b0101_0100,
  localparam int IDX_W  = $clog2(DIGITS),
  localparam int WORD_W = DIGITS * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_tick,
  input  logic [WORD_W-1:0] bcd_word,
  output logic [SEG_W-1:0]  seg_n,
  output logic [DIGITS-1:0] dig_n
);
  logic [IDX_W-1:0]  idx;
  logic [NIB_W-1:0]  nib;
  logic [DIGITS-1:0] pos_onehot;
  seg_pat_t          lit;

  scan_index_ctr #(.DIGITS(DIGITS)) u_idx (
    .clk(clk), .rst(rst), .step(scan_tick), .idx(idx)
  );

  digit_select #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_sel (
    .idx(idx), .word(bcd_word), .nib(nib), .pos_onehot(pos_onehot)
  );

  seg_encode #(.DIGITS(DIGITS), .DP_MASK(DP_MASK)) u_enc (
    .nib(nib), .pos_onehot(pos_onehot), .lit(lit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n <= '1;
      dig_n <= '1;
    end else begin
      seg_n <= ~lit;
      dig_n <= ~pos_onehot;
    end
  end
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
  parameter int DIGITS = 8,
  parameter logic [DIGITS-1:0] DP_MASK = 8'b0101_0100,
  localparam int IDX_W = $clog2(DIGITS)
) (
  input logic              clk,
  input logic              rst,
  input logic              scan_tick,
  input logic [IDX_W-1:0]  idx,
  input logic [7:0]        seg_n,
  input logic [DIGITS-1:0] dig_n
);
  logic seen_run;
  logic [IDX_W-1:0] idx_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_run <= 1'b0;
      idx_d    <= '0;
    end else begin
      seen_run <= 1'b1;
      idx_d    <= idx;
    end
  end

  AST_RESET_BLANK: assert property (@(posedge clk)
    rst |=> (seg_n == 8'hFF && dig_n == '1)); // R1

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    (seen_run && scan_tick) |=> idx == IDX_W'((32'(idx_d) + 1) % DIGITS)); // R2

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seen_run && !scan_tick) |=> $stable(idx)); // R2

  AST_ONE_POSITION: assert property (@(posedge clk) disable iff (rst)
    seen_run |-> $countones(~dig_n) == 1); // R3

  AST_POSITION_LAG: assert property (@(posedge clk) disable iff (rst)
    seen_run |-> dig_n[idx_d] == 1'b0); // R7

  AST_POINT_PLACE: assert property (@(posedge clk) disable iff (rst)
    (seen_run && |(~dig_n & ~DP_MASK)) |-> seg_n[0]); // R6
endmodule

bind seg_scan_top seg_scan_chk #(.DIGITS(DIGITS), .DP_MASK(DP_MASK)) u_chk (
  .clk(clk), .rst(rst), .scan_tick(scan_tick), .idx(idx),
  .seg_n(seg_n), .dig_n(dig_n)
);

// File: tb/test_seg_scan_top.sv
`timescale 1ns/1ps
module test_seg_scan_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_tick = 1'b0;
  logic [31:0] bcd_word = '0;
  logic [7:0]  seg_n;
  logic [7:0]  dig_n;
  int checks = 0;
  int failures = 0;
  int pos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_scan_top i_seg_scan_top (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .bcd_word(bcd_word),
    .seg_n(seg_n), .dig_n(dig_n)
  );

  function automatic logic [7:0] exp_seg(input logic [3:0] n, input int p);
    logic [7:0] a;
    case (n)
      4'd0: a = 8'hFC; 4'd1: a = 8'h60; 4'd2: a = 8'hDA; 4'd3: a = 8'hF2;
      4'd4: a = 8'h66; 4'd5: a = 8'hB6; 4'd6: a = 8'hBE; 4'd7: a = 8'hE0;
      4'd8: a = 8'hFE; 4'd9: a = 8'hF6; default: a = 8'h00;
    endcase
    if (n < 4'd10 && (p == 6 || p == 4 || p == 2)) a[0] = 1'b1;
    return ~a;
  endfunction

  task automatic check(input string req, input logic [7:0] es, input logic [7:0] ed);
    checks++;
    if (seg_n !== es || dig_n !== ed) begin
      failures++;
      $display("FAIL %s seg_n=%h dig_n=%h expected seg_n=%h dig_n=%h",
               req, seg_n, dig_n, es, ed);
    end
  endtask

  task automatic check_pos(input string req);
    check(req, exp_seg(bcd_word[pos*4 +: 4], pos), ~(8'h01 << pos));
  endtask

  task automatic tick();
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
    @(negedge clk);
    pos = (pos + 1) % 8;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 blank in reset", 8'hFF, 8'hFF);
    @(negedge clk) rst = 1'b0;
    pos = 0;
    @(negedge clk);
    check_pos("R1 first position 0");
  endtask

  task automatic t_scan(input logic [31:0] w, input string req);
    @(negedge clk) bcd_word = w;
    @(negedge clk);
    check_pos(req);
    for (int i = 0; i < 8; i++) begin
      tick();
      check_pos(req);
    end
  endtask

  task automatic t_hold();
    logic [7:0] s0, d0;
    @(negedge clk);
    s0 = seg_n; d0 = dig_n;
    repeat (5) @(negedge clk);
    check("R2 hold without strobe", s0, d0);
    bcd_word[pos*4 +: 4] = (bcd_word[pos*4 +: 4] == 4'd3) ? 4'd8 : 4'd3;
    checks++;
    #1;
    if (seg_n !== s0) begin
      failures++;
      $display("FAIL R7 early change seg_n=%h expected %h", seg_n, s0);
    end
    @(negedge clk);
    check_pos("R7 word change one cycle later");
  endtask

  task automatic t_wrap();
    while (pos != 7) tick();
    check_pos("R2 at position 7");
    tick();
    check_pos("R2 wrap to 0");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_scan(32'h1234_5678, "R3 R4 R6 digits 1-8");
    t_scan(32'h9087_6543, "R4 R6 digits 0,9");
    t_scan(32'hABCD_EF0F, "R5 blank codes");
    t_hold();
    t_wrap();
    t_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule